// File: doc/BRIEF.md
# Edge-Triggered One-Shot Pulse Generator

This block produces a single pulse of programmable length each time a chosen edge appears on an asynchronous trigger line. A 16-bit down-counter is stepped by a prescaled copy of the system clock. A valid trigger edge reloads the counter from the programmed width, clears the prescaler and drives the pulse output to its active level. When the counter steps past zero, the output returns to idle and a one-cycle underflow interrupt is raised. A polarity bit selects whether the pulse is high or low. Every valid trigger edge also sets a sticky trigger flag.

Software configures the block through a small byte-wide write port with four registers. Address 0 is the mode register. Bits [2:0] are the operating mode, bit 5 is the polarity and bit 7 is the alternate-function bit. The generator runs only when the operating mode is 3'b101 and bit 7 is 0. Addresses 1 and 2 hold the low and high bytes of the 16-bit width. Address 3 is the configuration register. Bits [3:0] select the divider, bit 4 selects the trigger edge, and writing 1 to bit 6 clears the trigger flag (bit 6 is not stored).

While the count-enable input is low, the count is frozen. A trigger that arrives in that state still drives the output active. The output then stays active until counting resumes.

Top module: `pulse_oneshot`

## Requirements
- R1: While reset is asserted and just after it is released, pulseOut, underflowIrq and trigFlag are all 0.
- R2: The generator runs only when mode bits [2:0] equal 3'b101 and mode bit 7 is 0. In any other mode a trigger edge leaves pulseOut at the idle level.
- R3: The idle level is the value of mode bit 5: 0 gives idle low and a high pulse, 1 gives idle high and a low pulse. On entering the one-shot mode, the output is at the idle level, even if a pulse was stuck active before the mode was left.
- R4: A valid trigger edge appears on pulseOut at the third rising clock edge after trigIn changes. The delay comes from two synchronizer stages and one edge-detect stage.
- R5: Configuration bit 4 selects the trigger edge: 1 selects the rising edge and 0 selects the falling edge. The opposite edge neither starts a pulse nor sets trigFlag.
- R6: The pulse lasts D*(W+1) clock cycles. W is the 16-bit width {addr 2, addr 1}. D is 2^(s+1), where s is configuration bits [3:0]. Values of s above 9 act as 9, so D ranges from 2 to 1024.
- R7: At the clock edge where the output returns to idle, underflowIrq goes high for exactly one cycle.
- R8: A valid trigger edge sets trigFlag in any mode. Writing configuration bit 6 = 1 clears trigFlag. If both happen in the same cycle, the set wins.
- R9: While countEn is 0, the count is frozen and an active output stays active. Once countEn returns to 1, the remaining pulse takes D*(W+1)-1 further cycles.
- R10: A valid trigger edge during a pulse reloads the width and clears the prescaler, so a full pulse is timed from the new trigger.
- R11: The width is sampled only when a trigger occurs. Rewriting the width registers during a pulse does not change that pulse, but does set the length of the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address: 0 mode, 1 width low, 2 width high, 3 configuration |
| wrData | input | 8 | Register write data |
| countEn | input | 1 | Count enable; 0 freezes the count |
| trigIn | input | 1 | Asynchronous trigger line |
| pulseOut | output | 1 | One-shot pulse output |
| underflowIrq | output | 1 | One-cycle underflow interrupt |
| trigFlag | output | 1 | Sticky trigger request flag |

## Verification
A trigger change driven at a falling clock edge reaches pulseOut and trigFlag three rising edges later. The bench therefore expects the first active sample at the third falling edge after it drives the trigger. The pulse then lasts D*(W+1) samples. underflowIrq is counted on the same sample where the output returns to idle, and over a few samples after it, and the bench expects exactly one. Register writes take effect at the rising edge inside the write task, so every check after a write samples at the next falling edge. For the frozen-count, retrigger and width-change cases, the expected number of active samples is worked out from these same delays.

// File: rtl/pulse_oneshot_pkg.sv
package pulse_oneshot_pkg;

  localparam int ADDR_W = 2;
  localparam logic [2:0] OP_ONESHOT = 3'b101;

  typedef enum logic [1:0] {
    REG_MODE = 2'd0,
    REG_WLO  = 2'd1,
    REG_WHI  = 2'd2,
    REG_CFG  = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;  // reload width, clear prescaler
    logic run;   // advance prescaler, allow counter step
  } dpStrobe_t;

endpackage

// File: rtl/pulse_oneshot_regs.sv
module pulse_oneshot_regs
  import pulse_oneshot_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 4,
  localparam int CNT_W  = 2 * DATA_W,
  localparam int NBYTES = CNT_W / DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              modeOn,
  output logic              polLow,
  output logic              edgeRise,
  output logic [SEL_W-1:0]  divSel,
  output logic [CNT_W-1:0]  width,
  output logic              flagClr
);

  logic [2:0]       opModeQ;
  logic             polQ;
  logic             altQ;
  logic             edgeQ;
  logic [SEL_W-1:0] divQ;
  logic [DATA_W-1:0] byteQ [NBYTES];

  logic wrMode, wrCfg;
  assign wrMode = wrEn && (wrAddr == REG_MODE);
  assign wrCfg  = wrEn && (wrAddr == REG_CFG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opModeQ <= '0;
      polQ    <= 1'b0;
      altQ    <= 1'b0;
    end else if (wrMode) begin
      opModeQ <= wrData[2:0];
      polQ    <= wrData[5];
      altQ    <= wrData[7];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divQ  <= '0;
      edgeQ <= 1'b0;
    end else if (wrCfg) begin
      divQ  <= wrData[SEL_W-1:0];
      edgeQ <= wrData[4];
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_wbyte
    logic hit;
    assign hit = wrEn && (wrAddr == ADDR_W'(int'(REG_WLO) + i));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    byteQ[i] <= '0;
      else if (hit) byteQ[i] <= wrData;
    end
    assign width[i*DATA_W +: DATA_W] = byteQ[i];
  end

  assign modeOn   = (opModeQ == OP_ONESHOT) && !altQ;
  assign polLow   = polQ;
  assign edgeRise = edgeQ;
  assign divSel   = divQ;
  assign flagClr  = wrCfg && wrData[6];

  // a mode write is visible on the next cycle
  AST_MODE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrMode |=> (modeOn == ($past(wrData[2:0]) == OP_ONESHOT && !$past(wrData[7])))); // R2

endmodule

// File: rtl/pulse_oneshot_ctrl.sv
module pulse_oneshot_ctrl
  import pulse_oneshot_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      trigIn,
  input  logic      countEn,
  input  logic      modeOn,
  input  logic      polLow,
  input  logic      edgeRise,
  input  logic      flagClr,
  input  logic      tick,
  input  logic      cntZero,
  output dpStrobe_t strobe,
  output logic      pulseOut,
  output logic      underflowIrq,
  output logic      trigFlag
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic trigNow, trigPrev;
  logic validEdge, underflow, activeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '0;
      trigPrev <= 1'b0;
    end else begin
      syncQ    <= {syncQ[SYNC_STAGES-2:0], trigIn};
      trigPrev <= trigNow;
    end
  end

  assign trigNow   = syncQ[SYNC_STAGES-1];
  assign validEdge = edgeRise ? (trigNow && !trigPrev) : (!trigNow && trigPrev);
  assign underflow = tick && cntZero;

  assign strobe.load = modeOn && validEdge;
  assign strobe.run  = modeOn && activeQ && countEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           activeQ <= 1'b0;
    else if (!modeOn)    activeQ <= 1'b0;
    else if (validEdge)  activeQ <= 1'b1;
    else if (underflow)  activeQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          trigFlag <= 1'b0;
    else if (validEdge) trigFlag <= 1'b1;
    else if (flagClr)   trigFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) underflowIrq <= 1'b0;
    else       underflowIrq <= underflow;
  end

  assign pulseOut = activeQ ^ polLow;

  AST_ENTRY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOn) |-> (pulseOut == polLow)); // R3
  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> activeQ); // R4
  AST_UNDERFLOW_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (underflow && !validEdge) |=> !activeQ); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    underflowIrq |=> !underflowIrq); // R7
  AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    validEdge |=> trigFlag); // R8

endmodule

// File: rtl/pulse_oneshot_dp.sv
module pulse_oneshot_dp
  import pulse_oneshot_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 4,
  parameter int N_DIV = 10,
  localparam int PRE_W = N_DIV
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] width,
  input  logic [SEL_W-1:0] divSel,
  output logic             tick,
  output logic             cntZero
);

  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(N_DIV - 1);

  logic [SEL_W-1:0] selClamped;
  logic [PRE_W-1:0] preMask;
  logic [PRE_W-1:0] preQ;
  logic [CNT_W-1:0] cntQ;

  assign selClamped = (divSel > LAST_SEL) ? LAST_SEL : divSel;

  // mask of low prescaler bits that must all be ones for a tick
  for (genvar b = 0; b < PRE_W; b++) begin : g_mask
    assign preMask[b] = (int'(selClamped) >= b);
  end

  assign tick    = strobe.run && ((preQ & preMask) == preMask);
  assign cntZero = (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            preQ <= '0;
    else if (strobe.load) preQ <= '0;
    else if (strobe.run)  preQ <= preQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cntQ <= '0;
    else if (strobe.load) cntQ <= width;
    else if (tick)        cntQ <= cntZero ? width : (cntQ - 1'b1);
  end

  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.run && !strobe.load) |=> $stable(cntQ)); // R9
  AST_LOAD_TAKES_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cntQ == $past(width))); // R10
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !cntZero && !strobe.load) |=> (cntQ == $past(cntQ) - 1'b1)); // R6

endmodule

// File: rtl/pulse_oneshot.sv
module pulse_oneshot
  import pulse_oneshot_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int N_DIV       = 10,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = 2 * DATA_W,
  localparam int SEL_W      = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              countEn,
  input  logic              trigIn,
  output logic              pulseOut,
  output logic              underflowIrq,
  output logic              trigFlag
);

  logic             modeOn, polLow, edgeRise, flagClr, tick, cntZero;
  logic [SEL_W-1:0] divSel;
  logic [CNT_W-1:0] width;
  dpStrobe_t        strobe;

  pulse_oneshot_regs #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .modeOn(modeOn), .polLow(polLow), .edgeRise(edgeRise), .divSel(divSel),
    .width(width), .flagClr(flagClr)
  );

  pulse_oneshot_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .trigIn(trigIn), .countEn(countEn),
    .modeOn(modeOn), .polLow(polLow), .edgeRise(edgeRise), .flagClr(flagClr),
    .tick(tick), .cntZero(cntZero), .strobe(strobe), .pulseOut(pulseOut),
    .underflowIrq(underflowIrq), .trigFlag(trigFlag)
  );

  pulse_oneshot_dp #(.CNT_W(CNT_W), .SEL_W(SEL_W), .N_DIV(N_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .width(width), .divSel(divSel),
    .tick(tick), .cntZero(cntZero)
  );

endmodule

// File: tb/pulse_oneshot_bench.sv
module pulse_oneshot_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic       countEn = 1'b1;
  logic       trigIn = 1'b0;
  logic       pulseOut, underflowIrq, trigFlag;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pulse_oneshot u_pulse_oneshot (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .countEn(countEn), .trigIn(trigIn), .pulseOut(pulseOut),
    .underflowIrq(underflowIrq), .trigFlag(trigFlag)
  );

  // {polarity, rising edge, divider select[3:0], width[15:0]}
  localparam logic [21:0] VECS [6] = '{
    {1'b0, 1'b1, 4'd0,  16'd0},
    {1'b1, 1'b0, 4'd1,  16'd3},
    {1'b0, 1'b0, 4'd2,  16'h0102},
    {1'b1, 1'b1, 4'd9,  16'd1},
    {1'b0, 1'b1, 4'd15, 16'd0},
    {1'b1, 1'b1, 4'd3,  16'h00FF}
  };

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // leave mode, preset line, program, clear flag, enter mode
  task automatic setup(input logic pol, input logic rise, input logic [3:0] div,
                       input logic [15:0] w, input logic [7:0] modeVal);
    wr(2'd0, 8'h00);
    @(negedge clk); trigIn = ~rise;
    repeat (4) @(negedge clk);
    wr(2'd1, w[7:0]);
    wr(2'd2, w[15:8]);
    wr(2'd3, {1'b0, 1'b1, 1'b0, rise, div});
    wr(2'd0, modeVal | {2'b00, pol, 5'b0});
  endtask

  task automatic measure(input logic actLvl, output int delay, output int len, output int irqs);
    delay = 0; len = 0; irqs = 0;
    while (pulseOut !== actLvl && delay < 8) begin
      @(negedge clk); delay++;
      if (underflowIrq) irqs++;
    end
    while (pulseOut === actLvl && len < 5000) begin
      len++;
      @(negedge clk);
      if (underflowIrq) irqs++;
    end
    repeat (3) begin
      @(negedge clk);
      if (underflowIrq) irqs++;
    end
  endtask

  function automatic int divOf(input logic [3:0] s);
    return 1 << (((s > 4'd9) ? 9 : int'(s)) + 1);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int d, l, q, n;
    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1 out in reset", pulseOut, 0);
    check("R1 irq in reset", underflowIrq, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 out after reset", pulseOut, 0);
    check("R1 flag after reset", trigFlag, 0);

    // table-driven pulses
    for (int i = 0; i < 6; i++) begin
      automatic logic [21:0] v = VECS[i];
      automatic logic pol = v[21];
      automatic logic rise = v[20];
      automatic int expLen = divOf(v[19:16]) * (int'(v[15:0]) + 1);
      countEn = 1'b1;
      setup(pol, rise, v[19:16], v[15:0], 8'h05);
      check("R3 idle level on entry", pulseOut, pol);
      check("R8 flag cleared", trigFlag, 0);
      @(negedge clk); trigIn = rise;
      measure(~pol, d, l, q);
      check("R4 trigger latency", d, 3);
      check("R6 pulse length", l, expLen);
      check("R7 single irq", q, 1);
      check("R8 flag set by edge", trigFlag, 1);
      check("R6 back to idle", pulseOut, pol);
    end

    // R5 opposite edge ignored
    setup(1'b0, 1'b1, 4'd0, 16'd2, 8'h05);
    @(negedge clk); trigIn = 1'b1;
    measure(1'b1, d, l, q);
    check("R5 selected edge fires", l, 6);
    wr(2'd3, 8'h50);
    @(negedge clk); trigIn = 1'b0;
    repeat (10) @(negedge clk);
    check("R5 falling edge no pulse", pulseOut, 0);
    check("R5 falling edge no flag", trigFlag, 0);

    // R2 mode not selected
    setup(1'b0, 1'b1, 4'd0, 16'd2, 8'h85);
    @(negedge clk); trigIn = 1'b1;
    repeat (12) @(negedge clk);
    check("R2 alt bit set no pulse", pulseOut, 0);
    check("R8 flag set with mode off", trigFlag, 1);
    setup(1'b0, 1'b1, 4'd0, 16'd2, 8'h04);
    @(negedge clk); trigIn = 1'b1;
    repeat (12) @(negedge clk);
    check("R2 other mode no pulse", pulseOut, 0);

    // R9 stopped count, R11 width rewrite
    setup(1'b0, 1'b1, 4'd0, 16'd3, 8'h05);
    countEn = 1'b0;
    @(negedge clk); trigIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R9 stuck active while stopped", pulseOut, 1);
    wr(2'd1, 8'd9);
    check("R9 still active after write", pulseOut, 1);
    @(negedge clk); countEn = 1'b1;
    n = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      if (pulseOut) n++; else break;
    end
    check("R11 running pulse keeps old width", n, 7);
    @(negedge clk); trigIn = 1'b0;
    repeat (4) @(negedge clk);
    trigIn = 1'b1;
    measure(1'b1, d, l, q);
    check("R11 next pulse uses new width", l, 20);

    // R3 stuck pulse cleared by leaving and re-entering
    setup(1'b0, 1'b1, 4'd0, 16'd0, 8'h05);
    countEn = 1'b0;
    @(negedge clk); trigIn = 1'b1;
    repeat (6) @(negedge clk);
    check("R9 stuck before reentry", pulseOut, 1);
    wr(2'd0, 8'h00);
    wr(2'd0, 8'h05);
    check("R3 reentry idles output", pulseOut, 0);
    countEn = 1'b1;

    // R10 retrigger mid pulse
    setup(1'b0, 1'b1, 4'd0, 16'd9, 8'h05);
    @(negedge clk); trigIn = 1'b1;
    q = 0;
    repeat (12) begin @(negedge clk); if (underflowIrq) q++; end
    trigIn = 1'b0;
    repeat (2) begin @(negedge clk); if (underflowIrq) q++; end
    trigIn = 1'b1;
    n = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (underflowIrq) q++;
      if (pulseOut) n++; else break;
    end
    check("R10 retrigger restarts width", n, 22);
    check("R7 one irq after retrigger", q, 1);

    // R8 clear by write
    wr(2'd3, 8'h50);
    check("R8 flag cleared by write", trigFlag, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule